// File: doc/BRIEF.md
# Shift-Based LMS Weight Update Unit

This unit applies the least-mean-square coefficient update to a four-tap adaptive filter. It works without a multiplier. The product of step size, error and input sample is approximated by a signed power of two, which is derived from the error. Each update pulse brings in a signed, already-delayed error value and the four delayed input samples that go with it. The unit holds the four coefficients in its own registers and feeds each updated set back as the base for the next update.

The position of the highest set bit in the error magnitude selects a right-shift amount. A large error gives a small shift and so a large step. Each tap sample is arithmetically shifted by that amount. The result is added to the tap's coefficient when the error is non-negative and subtracted when it is negative. The sum is clamped to the coefficient range.

The update runs in two register stages so that the critical path holds no more than one adder. The first stage registers the shifted increments and the add/subtract choice. The second stage performs the saturating addition into the coefficient registers.

Top module: `lms_shift_update`

## Requirements
- R1: While reset is low, and after its release, every coefficient reads 0 until the first update has passed through the pipeline.
- R2: The error magnitude is reduced to its 7 low magnitude bits. If the highest set bit of that magnitude is bit p (0..6), each tap's increment is its sample arithmetically shifted right by 6-p.
- R3: An error with sign bit 0 adds the increment to the coefficient. An error with sign bit 1 subtracts it.
- R4: An error of zero leaves all coefficients unchanged.
- R5: The shift is arithmetic. A negative sample rounds toward minus infinity, so -1 shifted by any amount stays -1, and -65 shifted by 6 gives -2.
- R6: A coefficient that would go above 32767 or below -32768 is held at that limit and does not wrap.
- R7: Updated coefficients appear after the second rising edge that follows a sampled `upd_en`. After the first edge they are still unchanged.
- R8: While `upd_en` is low, the coefficients hold whatever `err_in` and `x_in` do.
- R9: All four taps update in the same cycle, each from its own sample: tap i uses `x_in[8i+7:8i]` and writes `w_out[16i+15:16i]`.
- R10: The error value -128 is handled as magnitude 127 (shift 0), with the subtract direction.
- R11: When `upd_en` is held high on consecutive cycles, every pulse is applied in order, and each applies to the result of the one before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_en | input | 1 | Take one update from err_in and x_in this cycle |
| err_in | input | 8 | Delayed error, two's complement |
| x_in | input | 32 | Four delayed samples, two's complement, tap i at bits 8i+7:8i |
| w_out | output | 64 | Four registered coefficients, two's complement, tap i at bits 16i+15:16i |

## Verification
Every error value from -128 to 127 is swept with varied sample patterns, and the results are compared against an arithmetic model of the update. This exposes a priority encoder that picks the wrong bit (steps off by a power of two), a wrong sign choice (coefficients that drift away from the target), and a mishandled -128 (a zero step or the wrong direction). Directed cases shift negative samples by six bits, where a logical shift would yield large positive steps and a truncating divide would yield zero. A long run of maximum steps pushes taps into both limits, where a wrapping adder would flip the sign. Further cases hold the enable for several cycles to catch dropped or merged updates, and check one cycle after a pulse to catch a wrong pipeline depth.

// File: rtl/lms_shift_pkg.sv
package lms_shift_pkg;

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_SUB = 1'b1
    } upd_op_e;

endpackage

// File: rtl/lms_shift_code.sv
// Reduces a signed error to a shift code and an add/subtract choice.
module lms_shift_code
    import lms_shift_pkg::*;
#(
    parameter int EW = 8,
    localparam int MW = EW - 1,
    localparam int CW = $clog2(MW + 1)
) (
    input  logic [EW-1:0] err,
    output logic [CW-1:0] code,
    output upd_op_e       op
);
    logic [EW-1:0] neg;
    logic [MW-1:0] mag;

    always_comb begin
        neg = (~err) + {{(EW-1){1'b0}}, 1'b1};
        if (!err[EW-1]) begin
            mag = err[MW-1:0];
        end else if (neg[EW-1]) begin
            mag = {MW{1'b1}};          // most negative value: clamp magnitude
        end else begin
            mag = neg[MW-1:0];
        end
        op   = err[EW-1] ? OP_SUB : OP_ADD;
        code = CW'(MW);                // no bit set: zero step
        for (int b = 0; b < MW; b++) begin
            if (mag[b]) begin
                code = CW'(MW - 1 - b); // higher bits overwrite lower ones
            end
        end
    end

endmodule

// File: rtl/lms_shift_scaler.sv
// Arithmetic barrel shift of one tap sample into a weight-wide increment.
module lms_shift_scaler #(
    parameter int XW = 8,
    parameter int WW = 16,
    parameter int MW = 7,
    localparam int CW = $clog2(MW + 1)
) (
    input  logic [XW-1:0] x,
    input  logic [CW-1:0] code,
    output logic [WW-1:0] inc
);
    logic signed [WW-1:0] xe;
    logic signed [WW-1:0] sh;

    always_comb begin
        xe = {{(WW-XW){x[XW-1]}}, x};
        sh = xe >>> code;
        inc = (int'(code) >= MW) ? '0 : sh;
    end

endmodule

// File: rtl/lms_sat_accum.sv
// Saturating add or subtract of an increment into one weight.
module lms_sat_accum
    import lms_shift_pkg::*;
#(
    parameter int WW = 16
) (
    input  logic [WW-1:0] w,
    input  logic [WW-1:0] inc,
    input  upd_op_e       op,
    output logic [WW-1:0] w_nxt
);
    logic [WW:0] wx;
    logic [WW:0] ix;
    logic [WW:0] sum;

    always_comb begin
        wx = {w[WW-1], w};
        ix = {inc[WW-1], inc};
        sum = (op == OP_SUB) ? (wx - ix) : (wx + ix);
        if (sum[WW] != sum[WW-1]) begin
            w_nxt = sum[WW] ? {1'b1, {(WW-1){1'b0}}} : {1'b0, {(WW-1){1'b1}}};
        end else begin
            w_nxt = sum[WW-1:0];
        end
    end

endmodule

// File: rtl/lms_shift_update.sv
// Four-tap shift-based LMS weight update, two register stages.
module lms_shift_update
    import lms_shift_pkg::*;
#(
    parameter int NTAPS = 4,
    parameter int XW    = 8,
    parameter int EW    = 8,
    parameter int WW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_en,
    input  logic [EW-1:0]       err_in,
    input  logic [NTAPS*XW-1:0] x_in,
    output logic [NTAPS*WW-1:0] w_out
);
    localparam int MW = EW - 1;
    localparam int CW = $clog2(MW + 1);

    typedef struct packed {
        logic                      vld;
        upd_op_e                   op;
        logic [NTAPS-1:0][WW-1:0]  inc;
        logic [NTAPS-1:0][WW-1:0]  w;
    } upd_state_t;

    upd_state_t               st_d, st_q;
    logic [CW-1:0]            code;
    upd_op_e                  op_in;
    logic [NTAPS-1:0][WW-1:0] inc_w;
    logic [NTAPS-1:0][WW-1:0] w_nxt;

    logic                     stg_vld;
    logic                     stg_sub;
    logic [NTAPS*WW-1:0]      stg_inc;

    lms_shift_code #(.EW(EW)) u_code (
        .err  (err_in),
        .code (code),
        .op   (op_in)
    );

    for (genvar i = 0; i < NTAPS; i++) begin : g_tap
        lms_shift_scaler #(.XW(XW), .WW(WW), .MW(MW)) u_scale (
            .x    (x_in[i*XW +: XW]),
            .code (code),
            .inc  (inc_w[i])
        );
        lms_sat_accum #(.WW(WW)) u_acc (
            .w     (st_q.w[i]),
            .inc   (st_q.inc[i]),
            .op    (st_q.op),
            .w_nxt (w_nxt[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = upd_en;
        if (upd_en) begin
            st_d.op  = op_in;
            st_d.inc = inc_w;
        end
        if (st_q.vld) begin
            st_d.w = w_nxt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign w_out   = st_q.w;
    assign stg_vld = st_q.vld;
    assign stg_sub = (st_q.op == OP_SUB);
    assign stg_inc = st_q.inc;

endmodule

// File: rtl/lms_shift_chk.sv
module lms_shift_chk #(
    parameter int NTAPS = 4,
    parameter int WW    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                stg_vld,
    input logic                stg_sub,
    input logic [NTAPS*WW-1:0] stg_inc,
    input logic [NTAPS*WW-1:0] w_out
);
    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (w_out == '0));

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stg_vld |=> $stable(w_out));

    // R4
    zero_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_vld && stg_inc == '0) |=> $stable(w_out));

    for (genvar i = 0; i < NTAPS; i++) begin : g_dir
        // R3
        add_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stg_vld && !stg_sub && !stg_inc[i*WW+WW-1])
            |=> $signed(w_out[i*WW +: WW]) >= $signed($past(w_out[i*WW +: WW])));
        // R3
        sub_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (stg_vld && stg_sub && !stg_inc[i*WW+WW-1])
            |=> $signed(w_out[i*WW +: WW]) <= $signed($past(w_out[i*WW +: WW])));
    end

endmodule

bind lms_shift_update lms_shift_chk #(.NTAPS(NTAPS), .WW(WW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .stg_vld (stg_vld),
    .stg_sub (stg_sub),
    .stg_inc (stg_inc),
    .w_out   (w_out)
);

// File: tb/sim_lms_shift_update.sv
`timescale 1ns/1ps
module sim_lms_shift_update;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_en = 1'b0;
    logic [7:0]  err_in = '0;
    logic [31:0] x_in = '0;
    logic [63:0] w_out;

    int total = 0;
    int bad = 0;
    int mw [4];
    bit done = 0;

    always #2.5 clk = ~clk;

    lms_shift_update u0 (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en),
        .err_in(err_in), .x_in(x_in), .w_out(w_out)
    );

    function automatic int tap_w(int i);
        return int'($signed(w_out[i*16 +: 16]));
    endfunction

    function automatic int sat16(int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    // expected increment magnitude-signed: floor(x / 2^(6-p))
    function automatic int ref_inc(int e, int x);
        int mag, p, d, q;
        mag = (e < 0) ? -e : e;
        if (mag > 127) mag = 127;
        if (mag == 0) return 0;
        p = 0;
        for (int b = 0; b < 7; b++) if (mag >= (1 << b)) p = b;
        d = 1 << (6 - p);
        q = x / d;
        if (x < 0 && q * d != x) q = q - 1;
        return q;
    endfunction

    function automatic void model_apply(int e, int xs [4]);
        for (int i = 0; i < 4; i++) begin
            if (e < 0) mw[i] = sat16(mw[i] - ref_inc(e, xs[i]));
            else       mw[i] = sat16(mw[i] + ref_inc(e, xs[i]));
        end
    endfunction

    task automatic chk(int act, int exp, string req);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_all(string req);
        for (int i = 0; i < 4; i++) chk(tap_w(i), mw[i], req);
    endtask

    task automatic drive(int e, int xs [4]);
        err_in = 8'(e);
        for (int i = 0; i < 4; i++) x_in[i*8 +: 8] = 8'(xs[i]);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; upd_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) mw[i] = 0;
        @(negedge clk);
        chk_all("R1");
    endtask

    // single pulse; checks the one-edge-late state too
    task automatic pulse(int e, int xs [4], string req);
        drive(e, xs);
        upd_en = 1'b1;
        @(negedge clk);
        upd_en = 1'b0;
        chk_all("R7");
        @(negedge clk);
        model_apply(e, xs);
        chk_all(req);
    endtask

    initial begin
        int xs [4];
        do_reset();

        // R5 and R9: e=1 gives shift 6, negative samples round down
        xs = '{-1, -65, 63, 64};
        pulse(1, xs, "R5");
        chk(tap_w(0), -1, "R5");
        chk(tap_w(1), -2, "R5");
        chk(tap_w(2), 0, "R5");
        chk(tap_w(3), 1, "R9");

        // R8: inputs move, enable low
        for (int k = 0; k < 6; k++) begin
            xs = '{k*20 - 60, 100 - k, -k, 7};
            drive(k * 30 - 90, xs);
            @(negedge clk);
        end
        chk_all("R8");

        // R2, R3, R4, R10: sweep all error values
        for (int e = -128; e <= 127; e++) begin
            string req;
            for (int i = 0; i < 4; i++) xs[i] = ((e * 37 + i * 53 + 11) & 255) - 128;
            if (e == 0) req = "R4";
            else if (e == -128) req = "R10";
            else if (e < 0) req = "R3";
            else req = "R2";
            pulse(e, xs, req);
        end

        // R10 directed: -128 with sample 4 subtracts 4 exactly
        do_reset();
        xs = '{4, -4, 0, 1};
        pulse(-128, xs, "R10");
        chk(tap_w(0), -4, "R10");
        chk(tap_w(1), 4, "R10");

        // R2 directed: e=8 (bit 3) shifts by 3
        do_reset();
        xs = '{80, -80, 7, -9};
        pulse(8, xs, "R2");
        chk(tap_w(0), 10, "R2");
        chk(tap_w(1), -10, "R2");
        chk(tap_w(2), 0, "R2");
        chk(tap_w(3), -2, "R2");

        // R6: drive taps into both limits
        do_reset();
        xs = '{127, -128, 0, 1};
        for (int k = 0; k < 270; k++) pulse(127, xs, "R6");
        chk(tap_w(0), 32767, "R6");
        chk(tap_w(1), -32768, "R6");
        chk(tap_w(2), 0, "R6");
        chk(tap_w(3), 270, "R6");

        // R11: back-to-back enables
        do_reset();
        upd_en = 1'b1;
        xs = '{100, -50, 20, 3};  drive(64, xs);  model_apply(64, xs);
        @(negedge clk);
        xs = '{-7, 90, 33, -128}; drive(-5, xs);  model_apply(-5, xs);
        @(negedge clk);
        xs = '{55, 55, -55, 127}; drive(17, xs);  model_apply(17, xs);
        @(negedge clk);
        upd_en = 1'b0;
        @(negedge clk);
        chk_all("R11");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule